// File: doc/BRIEF.md
# Padded 3x3 Window Line Buffer

This block turns a raster-ordered stream of packed three-channel pixels of a small fixed-size image into a stream of 3x3 neighbourhoods, one for every pixel position of the image, with stride 1. A one-pixel ring of zeros is placed around the image. The padding samples are made inside the block and never come from upstream, so the window grid has the same size as the image. Each window carries all three colour planes side by side, so a convolution stage downstream can work on every input channel in the same cycle.

Internally the block walks a padded grid that is two samples wider and taller than the image. Two shift-register row buffers, each one padded row long, supply the two earlier rows. Two delay registers per row supply the two earlier columns. Both streams use valid/ready handshakes. A frame begins with a pixel that carries a start-of-frame flag. That pixel clears all stored rows, and the block then takes exactly one image's worth of pixels. When downstream holds off, the block stops the whole walk, so no window is dropped or repeated.

Top module: `lb3_window_gen`

## Requirements
- R1: While reset is held and right after it is released, `out_valid` and `in_ready` are both low.
- R2: No frame is active after reset or after a frame ends. In that state `in_ready` stays low while unflagged pixels are offered (`in_sof` low). A pixel offered with `in_sof` high starts a frame and is later taken as image pixel (row 0, column 0).
- R3: A frame takes exactly IMG_W*IMG_H pixels (1024 by default). After that `in_ready` stays low until the next flagged pixel.
- R4: A frame produces exactly IMG_W*IMG_H windows. Their `out_row`/`out_col` values run in raster order from (0,0), with the column changing fastest, and `out_valid` is low once the last one has been taken.
- R5: Window element (wr,wc), with wr and wc in 0..2 and (0,0) at top-left, of the window at (row,col) equals the image pixel at (row+wr-1, col+wc-1). It is zero when that position lies outside the image.
- R6: Channel k of a pixel is `in_pixel[8k+7:8k]`. Channel k of window element (wr,wc) sits in `out_win` at bits starting at 8*(9k+3wr+wc).
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_win`, `out_row` and `out_col` hold their values. `out_valid` falls only after a transfer.
- R8: A frame's windows depend only on that frame's pixels. A frame that follows a frame of all-ones pixels still shows zeros at its border positions.
- R9: Gaps in the input (`in_valid` low) change neither the contents nor the order of the windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block takes the offered pixel this cycle |
| in_sof | input | 1 | Offered pixel is the first of a frame |
| in_pixel | input | 24 | Packed pixel, channel k in bits [8k+7:8k] |
| out_valid | output | 1 | Window present on out_win |
| out_ready | input | 1 | Downstream takes the window this cycle |
| out_win | output | 216 | Three channels of 3x3 elements, layout per R6 |
| out_row | output | 5 | Image row of the window centre |
| out_col | output | 5 | Image column of the window centre |

## Verification
The hardest case is a stall that falls on a padding-only stretch, such as the bottom padded row. There the block advances with no input at all, and only output back-pressure can stop it. Another hard case is a stall that falls just as a padded row wraps into the next one. To reach these, one frame combines periodic input gaps with an output ready that drops every third cycle, so stalls land at every phase of the padded walk, including the last row and the row turnovers. A frame of all-ones pixels placed just before a patterned frame shows any stale row that survives the frame change. Any such row would appear as nonzero border elements.

// File: rtl/lb3_pkg.sv
`timescale 1ns/1ps
package lb3_pkg;

  // Slot index of channel ch, window row wr, window column wc inside out_win.
  function automatic int unsigned win_slot(int unsigned ch, int unsigned wr, int unsigned wc);
    return (ch * 3 + wr) * 3 + wc;
  endfunction

  // True on the zero ring around the image in padded coordinates.
  function automatic logic ring_pos(int unsigned pr, int unsigned pc,
                                    int unsigned img_w, int unsigned img_h);
    return (pr == 0) || (pc == 0) || (pr == img_h + 1) || (pc == img_w + 1);
  endfunction

endpackage

// File: rtl/lb3_scan.sv
`timescale 1ns/1ps
module lb3_scan #(
  parameter int IMG_W = 32,
  parameter int IMG_H = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          adv,
  output logic                          busy,
  output logic [$clog2(IMG_H+2)-1:0]    pr,
  output logic [$clog2(IMG_W+2)-1:0]    pc,
  output logic                          ring,
  output logic                          win_pos
);
  localparam int PW  = IMG_W + 2;
  localparam int PH  = IMG_H + 2;
  localparam int RWP = $clog2(PH);
  localparam int CWP = $clog2(PW);

  logic last_pos;

  assign last_pos = (pr == RWP'(PH - 1)) && (pc == CWP'(PW - 1));
  assign ring     = lb3_pkg::ring_pos(int'(pr), int'(pc), IMG_W, IMG_H);
  assign win_pos  = (pr >= RWP'(2)) && (pc >= CWP'(2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pr   <= '0;
      pc   <= '0;
    end else if (start) begin
      busy <= 1'b1;
      pr   <= '0;
      pc   <= '0;
    end else if (adv) begin
      if (last_pos) begin
        busy <= 1'b0;
        pr   <= '0;
        pc   <= '0;
      end else if (pc == CWP'(PW - 1)) begin
        pc <= '0;
        pr <= pr + 1'b1;
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

  // R3: a frame closes only on the advance over the last padded position
  p_frame_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(last_pos && adv));

endmodule

// File: rtl/lb3_rowbuf.sv
`timescale 1ns/1ps
module lb3_rowbuf #(
  parameter int DW  = 24,
  parameter int LEN = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] st [LEN];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < LEN; i++) st[i] <= '0;
    end else if (en) begin
      st[0] <= din;
      for (int i = 1; i < LEN; i++) st[i] <= st[i-1];
    end
  end

  assign dout = st[LEN-1];

endmodule

// File: rtl/lb3_window_gen.sv
`timescale 1ns/1ps
module lb3_window_gen #(
  parameter int IMG_W = 32,
  parameter int IMG_H = 32,
  parameter int CH_W  = 8,
  parameter int NCH   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         in_sof,
  input  logic [NCH*CH_W-1:0]          in_pixel,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [9*NCH*CH_W-1:0]        out_win,
  output logic [$clog2(IMG_H)-1:0]     out_row,
  output logic [$clog2(IMG_W)-1:0]     out_col
);
  localparam int PIX_W = NCH * CH_W;
  localparam int WIN_W = 9 * PIX_W;
  localparam int PW    = IMG_W + 2;
  localparam int RWP   = $clog2(IMG_H + 2);
  localparam int CWP   = $clog2(PW);
  localparam int ORW   = $clog2(IMG_H);
  localparam int OCW   = $clog2(IMG_W);
  localparam int NBUF  = 2;

  // Control events, named for the assertions
  logic            busy, ring, win_pos, start, slot_free, adv, emit;
  logic [RWP-1:0]  pr;
  logic [CWP-1:0]  pc;
  logic [PIX_W-1:0] sample;

  assign start     = !busy && in_valid && in_sof;
  assign slot_free = !out_valid || out_ready;
  assign adv       = busy && (ring || in_valid) && (!win_pos || slot_free);
  assign emit      = adv && win_pos;
  assign in_ready  = busy && !ring && (!win_pos || slot_free);
  assign sample    = ring ? '0 : in_pixel;

  lb3_scan #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
    .busy(busy), .pr(pr), .pc(pc), .ring(ring), .win_pos(win_pos)
  );

  // Row buffers in a chain: stage 0 holds the previous row, stage 1 the one before
  logic [PIX_W-1:0] rb_out [NBUF];
  genvar g;
  generate
    for (g = 0; g < NBUF; g++) begin : g_rb
      if (g == 0) begin : g_head
        lb3_rowbuf #(.DW(PIX_W), .LEN(PW)) u_rb (
          .clk(clk), .rst_n(rst_n), .clr(start), .en(adv),
          .din(sample), .dout(rb_out[g]));
      end else begin : g_tail
        lb3_rowbuf #(.DW(PIX_W), .LEN(PW)) u_rb (
          .clk(clk), .rst_n(rst_n), .clr(start), .en(adv),
          .din(rb_out[g-1]), .dout(rb_out[g]));
      end
    end
  endgenerate

  // Newest column of each window row (0 = top)
  logic [PIX_W-1:0] cur [3];
  assign cur[0] = rb_out[1];
  assign cur[1] = rb_out[0];
  assign cur[2] = sample;

  // Horizontal delays: d1 = one column back, d2 = two columns back
  logic [PIX_W-1:0] d1 [3];
  logic [PIX_W-1:0] d2 [3];

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      for (int r = 0; r < 3; r++) begin
        d1[r] <= '0;
        d2[r] <= '0;
      end
    end else if (adv) begin
      for (int r = 0; r < 3; r++) begin
        d1[r] <= cur[r];
        d2[r] <= d1[r];
      end
    end
  end

  logic [PIX_W-1:0] tap [3][3];
  always_comb begin
    for (int r = 0; r < 3; r++) begin
      tap[r][0] = d2[r];
      tap[r][1] = d1[r];
      tap[r][2] = cur[r];
    end
  end

  logic [WIN_W-1:0] win_next;
  always_comb begin
    win_next = '0;
    for (int k = 0; k < NCH; k++)
      for (int wr = 0; wr < 3; wr++)
        for (int wc = 0; wc < 3; wc++)
          win_next[lb3_pkg::win_slot(k, wr, wc) * CH_W +: CH_W] = tap[wr][wc][k*CH_W +: CH_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_win   <= '0;
      out_row   <= '0;
      out_col   <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_win   <= win_next;
      out_row   <= ORW'(pr - RWP'(2));
      out_col   <= OCW'(pc - CWP'(2));
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // Border content of the presented window, for the assertions
  logic top_nz, left_nz;
  always_comb begin
    top_nz  = 1'b0;
    left_nz = 1'b0;
    for (int k = 0; k < NCH; k++)
      for (int j = 0; j < 3; j++) begin
        top_nz  = top_nz  | (|out_win[lb3_pkg::win_slot(k, 0, j) * CH_W +: CH_W]);
        left_nz = left_nz | (|out_win[lb3_pkg::win_slot(k, j, 0) * CH_W +: CH_W]);
      end
  end

  p_top_ring_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_row == '0) |-> !top_nz);

  p_left_ring_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_col == '0) |-> !left_nz);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_win) &&
                                   $stable(out_row) && $stable(out_col)));

  p_drop_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

endmodule

// File: tb/sim_lb3_window_gen.sv
`timescale 1ns/1ps
module sim_lb3_window_gen;
  localparam int W = 32, H = 32, CB = 8, NC = 3;
  localparam int PIXW = NC * CB;
  localparam int WINW = 9 * PIXW;
  localparam int NPIX = W * H;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, in_valid, in_ready, in_sof, out_valid, out_ready;
  logic [PIXW-1:0] in_pixel;
  logic [WINW-1:0] out_win;
  logic [4:0] out_row, out_col;

  int checks = 0, errors = 0;

  lb3_window_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_pixel(in_pixel), .out_valid(out_valid),
    .out_ready(out_ready), .out_win(out_win), .out_row(out_row), .out_col(out_col));

  task automatic chk(input bit ok, input string req, input logic [WINW-1:0] act,
                     input logic [WINW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Test image: solid = all ones, otherwise a nonzero pattern per channel
  function automatic logic [PIXW-1:0] pix(input int seed, input bit solid, input int r, input int c);
    logic [PIXW-1:0] p;
    if (solid) return '1;
    for (int k = 0; k < NC; k++)
      p[8*k +: 8] = 8'(((r * 7 + c * 13 + k * 61 + seed) % 255) + 1);
    return p;
  endfunction

  function automatic logic [WINW-1:0] exp_win(input int seed, input bit solid, input int r, input int c);
    logic [WINW-1:0] w = '0;
    for (int wr = 0; wr < 3; wr++)
      for (int wc = 0; wc < 3; wc++) begin
        int rr = r + wr - 1;
        int cc = c + wc - 1;
        if (rr >= 0 && rr < H && cc >= 0 && cc < W) begin
          logic [PIXW-1:0] p = pix(seed, solid, rr, cc);
          for (int k = 0; k < NC; k++)
            w[k*72 + wr*24 + wc*8 +: 8] = p[8*k +: 8];
        end
      end
    return w;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_pixel = '0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R1 in reset", {out_valid, in_ready}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R1 after reset", {out_valid, in_ready}, '0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_pixel = 24'hABCDEF;
      #1;
      chk(in_ready == 1'b0, "R2 unflagged pixel not taken", in_ready, 0);
      chk(out_valid == 1'b0, "R2 no window while idle", out_valid, 0);
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  // One frame; gaps add input bubbles (R9), stalls drop out_ready every third cycle (R7)
  task automatic t_frame(input int seed, input bit solid, input bit gaps, input bit stalls);
    fork
      begin : drive
        int idx = 0, cyc = 0;
        while (idx < NPIX) begin
          @(negedge clk);
          cyc++;
          if (gaps && (cyc % 5) == 3) begin
            in_valid = 1'b0; in_sof = 1'b0;
          end else begin
            in_valid = 1'b1; in_sof = (idx == 0);
            in_pixel = pix(seed, solid, idx / W, idx % W);
          end
          #1;
          if (in_valid && in_ready) idx++;
        end
        @(negedge clk); in_valid = 1'b0; in_sof = 1'b0;
      end
      begin : recv
        int n = 0, cyc = 0;
        bit held = 0;
        logic [WINW-1:0] s_win;
        logic [4:0] s_row, s_col;
        while (n < NPIX) begin
          @(negedge clk);
          cyc++;
          if (held)
            chk(out_valid && out_win == s_win && out_row == s_row && out_col == s_col,
                "R7 held during stall", out_win, s_win);
          out_ready = stalls ? ((cyc % 3) != 0) : 1'b1;
          #1;
          held = out_valid && !out_ready;
          s_win = out_win; s_row = out_row; s_col = out_col;
          if (out_valid && out_ready) begin
            logic [WINW-1:0] e = exp_win(seed, solid, n / W, n % W);
            chk(out_row == 5'(n / W) && out_col == 5'(n % W), "R4 raster coordinates",
                {out_row, out_col}, {5'(n / W), 5'(n % W)});
            chk(out_win == e, gaps ? "R5/R9 window under gaps" : "R5/R8 window content", out_win, e);
            if (n == W + 1) begin
              logic [PIXW-1:0] p = pix(seed, solid, 1, 1);
              chk(out_win[8*(9*2+4) +: 8] == p[23:16], "R6 channel 2 centre field",
                  out_win[8*(9*2+4) +: 8], p[23:16]);
            end
            n++;
          end
        end
        out_ready = 1'b1;
      end
    join
    repeat (3) @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b0; in_pixel = 24'h123456;
    #1;
    chk(in_ready == 1'b0, "R3 no pixel beyond frame", in_ready, 0);
    chk(out_valid == 1'b0, "R4 no window beyond frame", out_valid, 0);
    @(negedge clk); in_valid = 1'b0;
  endtask

  initial begin
    t_reset();
    t_idle();
    t_frame(5, 1'b0, 1'b0, 1'b0);
    t_frame(0, 1'b1, 1'b0, 1'b0);
    t_frame(77, 1'b0, 1'b0, 1'b0);   // R8: follows the all-ones frame
    t_frame(140, 1'b0, 1'b1, 1'b1);  // R7 and R9
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule